// File: doc/BRIEF.md
# Byte-Serial Instruction Length Decoder

The block accepts a stream of variable-length machine instructions, one byte per clock, and finds where each instruction ends. It takes the bytes one at a time. The first byte is the opcode. The opcode decides whether an operand-descriptor byte follows. The mode field of that descriptor byte decides how many address-offset bytes come next. When an instruction has a trailing constant, that constant comes last. When the final byte of an instruction has been accepted, the block presents the fields it found and the total byte count for one cycle.

Two instruction forms are recognised:
- The one-byte register push. Its opcode range is 0x50 to 0x57, and the low three opcode bits name the register.
- Opcode 0x81. This is an arithmetic or logic operation with a 16-bit constant. The descriptor's middle field selects the operation, and the value 7 selects compare.

Any other first byte is reported as illegal, and decoding restarts with the byte that follows it. The block does not compute addresses, execute instructions or handle prefixes.

Top module: `insn_len_decoder`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_valid` are 0. From the first clock edge after reset is released, `in_ready` is 1.
- R2: An opcode from 0x50 to 0x57 is a complete instruction of length 1. It is reported with `out_mod`=3, `out_reg`=0, `out_rm` equal to the opcode's bits 2:0, `out_disp`=0, `out_imm`=0 and `out_illegal`=0.
- R3: After opcode 0x81, the next byte is the operand descriptor. `out_mod` is its bits 7:6, `out_reg` is its bits 5:3 and `out_rm` is its bits 2:0.
- R4: A descriptor with mode 0 and rm other than 6 has no offset bytes. `out_disp` is 0 and `out_len` is 4.
- R5: Mode 1 takes one offset byte, which is sign-extended to 16 bits, and `out_len` is 5. For example, the stream 81 7E 08 CD AB gives reg 7, rm 6, disp 0x0008, imm 0xABCD and length 5.
- R6: Mode 2 takes two offset bytes, low byte first, and `out_len` is 6.
- R7: Mode 0 with rm 6 is a direct address. It takes two offset bytes, low byte first, and `out_len` is 6.
- R8: Mode 3 names a register and takes no offset bytes. `out_len` is 4. For example, the stream 81 FA CD AB gives mod 3, reg 7, rm 2, imm 0xABCD and length 4.
- R9: For opcode 0x81, the two bytes after any offset bytes form `out_imm`, low byte first.
- R10: Any first byte other than 0x50 to 0x57 and 0x81 is reported with `out_illegal`=1 and `out_len`=1. All other fields are 0 except `out_opcode`. The next byte is decoded as a new opcode.
- R11: A byte is consumed only in a cycle where `in_valid` and `in_ready` are both 1. Idle cycles inserted anywhere in an instruction do not change its decoded result.
- R12: `out_valid` is high for exactly one cycle per instruction. That cycle is the one after the edge that accepted the instruction's last byte. `out_len` is always between 1 and 6, and no other cycle raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction byte is offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | One-cycle pulse: decoded instruction is presented |
| out_illegal | output | 1 | The opcode was not recognised |
| out_opcode | output | 8 | Opcode byte |
| out_mod | output | 2 | Descriptor mode field |
| out_reg | output | 3 | Descriptor middle field (operation select) |
| out_rm | output | 3 | Descriptor low field, or register index for push |
| out_disp | output | 16 | Address offset, sign-extended when one byte |
| out_imm | output | 16 | Constant operand |
| out_len | output | 3 | Total instruction length in bytes |

## Verification
The bench covers the following input patterns:
- All 256 descriptor byte values after opcode 0x81. This sweep separates the four modes from each other and from the special mode 0 / rm 6 case. The offset and constant bytes vary with the descriptor value, so sign extension, byte order and the placement of the constant after the offset are all checked.
- All eight push opcodes, which show that the register index is taken from the opcode.
- Every unsupported opcode, each followed directly by a push. This shows that decoding restarts on the byte after an illegal opcode.
- A second run of descriptor values with pseudo-random idle gaps between bytes. It shows that stalls change only the timing, not the decoded fields.

// File: rtl/ild_pkg.sv
package ild_pkg;

  localparam int unsigned BW = 8;
  localparam int unsigned WW = 2 * BW;
  localparam int unsigned LW = 3;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_MODRM,
    ST_DLO,
    ST_DHI,
    ST_ILO,
    ST_IHI
  } ild_state_e;

  typedef struct packed {
    logic [1:0] md;
    logic [2:0] rg;
    logic [2:0] rm;
  } modrm_t;

  // number of offset bytes implied by a descriptor
  function automatic logic [1:0] disp_len(input logic [1:0] md, input logic [2:0] rm);
    logic [1:0] n;
    case (md)
      2'd0:    n = (rm == 3'd6) ? 2'd2 : 2'd0;
      2'd1:    n = 2'd1;
      2'd2:    n = 2'd2;
      default: n = 2'd0;
    endcase
    return n;
  endfunction

  function automatic logic [WW-1:0] sext_byte(input logic [BW-1:0] b);
    return {{(WW-BW){b[BW-1]}}, b};
  endfunction

  // opcode + descriptor + offset + two constant bytes
  function automatic logic [LW-1:0] grp_len(input logic [1:0] nd);
    return LW'(4) + LW'(nd);
  endfunction

endpackage

// File: rtl/ild_opc_class.sv
module ild_opc_class
  import ild_pkg::*;
#(
  parameter logic [BW-1:0] PUSH_BASE = 8'h50,
  parameter logic [BW-1:0] GRP_OPC   = 8'h81
) (
  input  logic [BW-1:0] opc,
  output logic          is_push,
  output logic          is_grp,
  output logic [2:0]    push_reg
);
  // push family occupies an aligned block of eight opcodes
  assign is_push  = (opc[BW-1:3] == PUSH_BASE[BW-1:3]);
  assign is_grp   = (opc == GRP_OPC);
  assign push_reg = opc[2:0];
endmodule

// File: rtl/ild_modrm_split.sv
module ild_modrm_split
  import ild_pkg::*;
(
  input  logic [BW-1:0] byte_in,
  output modrm_t        fields,
  output logic [1:0]    ndisp
);
  assign fields.md = byte_in[7:6];
  assign fields.rg = byte_in[5:3];
  assign fields.rm = byte_in[2:0];
  assign ndisp     = disp_len(byte_in[7:6], byte_in[2:0]);
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
#(
  parameter logic [BW-1:0] PUSH_BASE = 8'h50,
  parameter logic [BW-1:0] GRP_OPC   = 8'h81
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_illegal,
  output logic [7:0]    out_opcode,
  output logic [1:0]    out_mod,
  output logic [2:0]    out_reg,
  output logic [2:0]    out_rm,
  output logic [15:0]   out_disp,
  output logic [15:0]   out_imm,
  output logic [2:0]    out_len
);

  ild_state_e    state_q;
  logic [BW-1:0] opc_q;
  modrm_t        mrm_q;
  logic [1:0]    nd_q;
  logic [WW-1:0] disp_q;
  logic [BW-1:0] imm_lo_q;
  logic          rdy_q;

  logic          is_push, is_grp;
  logic [2:0]    push_reg;
  modrm_t        mrm_d;
  logic [1:0]    nd_d;

  // named events for the assertions
  logic take, done_push, done_bad, done_grp;

  ild_opc_class #(.PUSH_BASE(PUSH_BASE), .GRP_OPC(GRP_OPC)) i_class (
    .opc(in_data), .is_push(is_push), .is_grp(is_grp), .push_reg(push_reg)
  );

  ild_modrm_split i_split (
    .byte_in(in_data), .fields(mrm_d), .ndisp(nd_d)
  );

  assign in_ready  = rdy_q;
  assign take      = in_valid && rdy_q;
  assign done_push = take && (state_q == ST_OPC) && is_push;
  assign done_bad  = take && (state_q == ST_OPC) && !is_push && !is_grp;
  assign done_grp  = take && (state_q == ST_IHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_OPC;
      rdy_q       <= 1'b0;
      opc_q       <= '0;
      mrm_q       <= '0;
      nd_q        <= '0;
      disp_q      <= '0;
      imm_lo_q    <= '0;
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_opcode  <= '0;
      out_mod     <= '0;
      out_reg     <= '0;
      out_rm      <= '0;
      out_disp    <= '0;
      out_imm     <= '0;
      out_len     <= '0;
    end else begin
      rdy_q     <= 1'b1;
      out_valid <= 1'b0;
      if (take) begin
        case (state_q)
          ST_OPC: begin
            opc_q <= in_data;
            if (is_push) begin
              out_valid   <= 1'b1;
              out_illegal <= 1'b0;
              out_opcode  <= in_data;
              out_mod     <= 2'd3;
              out_reg     <= 3'd0;
              out_rm      <= push_reg;
              out_disp    <= '0;
              out_imm     <= '0;
              out_len     <= LW'(1);
            end else if (is_grp) begin
              state_q <= ST_MODRM;
            end else begin
              out_valid   <= 1'b1;
              out_illegal <= 1'b1;
              out_opcode  <= in_data;
              out_mod     <= '0;
              out_reg     <= '0;
              out_rm      <= '0;
              out_disp    <= '0;
              out_imm     <= '0;
              out_len     <= LW'(1);
            end
          end
          ST_MODRM: begin
            mrm_q   <= mrm_d;
            nd_q    <= nd_d;
            disp_q  <= '0;
            state_q <= (nd_d != 2'd0) ? ST_DLO : ST_ILO;
          end
          ST_DLO: begin
            if (nd_q == 2'd1) begin
              disp_q  <= sext_byte(in_data);
              state_q <= ST_ILO;
            end else begin
              disp_q  <= {{(WW-BW){1'b0}}, in_data};
              state_q <= ST_DHI;
            end
          end
          ST_DHI: begin
            disp_q[WW-1:BW] <= in_data;
            state_q         <= ST_ILO;
          end
          ST_ILO: begin
            imm_lo_q <= in_data;
            state_q  <= ST_IHI;
          end
          ST_IHI: begin
            out_valid   <= 1'b1;
            out_illegal <= 1'b0;
            out_opcode  <= opc_q;
            out_mod     <= mrm_q.md;
            out_reg     <= mrm_q.rg;
            out_rm      <= mrm_q.rm;
            out_disp    <= disp_q;
            out_imm     <= {in_data, imm_lo_q};
            out_len     <= grp_len(nd_q);
            state_q     <= ST_OPC;
          end
          default: state_q <= ST_OPC;
        endcase
      end
    end
  end

  // R12: reported length always in range
  p_len_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd6));

  // R12: a report needs a byte accepted on the edge before
  p_emit_after_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(take));

  // R2: push is a one-byte legal instruction
  p_push_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_push |=> (out_valid && out_len == 3'd1 && !out_illegal));

  // R10: illegal opcode reported and decoder back at opcode stage
  p_bad_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_bad |=> (out_valid && out_illegal && out_len == 3'd1 && state_q == ST_OPC));

  // R4: multi-byte length matches the reported descriptor
  p_grp_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && out_len != 3'd1)
      |-> (out_len == 3'd4 + 3'(disp_len(out_mod, out_rm))));

  // R5: single offset byte is sign-extended
  p_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && out_len == 3'd5)
      |-> (out_disp[15:8] == {8{out_disp[7]}}));

  // R11: without a transfer nothing advances and nothing is reported
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(state_q) && !out_valid));

  // R12: the final constant byte ends the instruction
  p_grp_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_grp |=> (out_valid && state_q == ST_OPC));

endmodule

// File: tb/test_insn_len_decoder.sv
`timescale 1ns/1ps
module test_insn_len_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready, out_valid, out_illegal;
  logic [7:0]  out_opcode;
  logic [1:0]  out_mod;
  logic [2:0]  out_reg, out_rm, out_len;
  logic [15:0] out_disp, out_imm;

  always #4 clk = ~clk;

  insn_len_decoder i_insn_len_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_opcode(out_opcode), .out_mod(out_mod), .out_reg(out_reg),
    .out_rm(out_rm), .out_disp(out_disp), .out_imm(out_imm), .out_len(out_len)
  );

  typedef struct packed {
    logic        ill;
    logic [7:0]  opc;
    logic [1:0]  md;
    logic [2:0]  rg;
    logic [2:0]  rm;
    logic [15:0] disp;
    logic [15:0] imm;
    logic [2:0]  len;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic report;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  function automatic int pick_gap(input int gmax);
    int g;
    if (gmax == 0) return 0;
    g = int'(lfsr[3:0]) % (gmax + 1);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return g;
  endfunction

  task automatic drive(input logic [7:0] b, input int gmax);
    int g = pick_gap(gmax);
    for (int k = 0; k < g; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'h00;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
  endtask

  task automatic go_idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_push(input logic [2:0] r);
    exp_t e = '0;
    e.opc = 8'h50 + {5'd0, r};
    e.md  = 2'd3;
    e.rm  = r;
    e.len = 3'd1;
    exp_q.push_back(e);
    tag_q.push_back("R2");
    drive(e.opc, 0);
  endtask

  task automatic send_bad(input logic [7:0] op);
    exp_t e = '0;
    e.ill = 1'b1;
    e.opc = op;
    e.len = 3'd1;
    exp_q.push_back(e);
    tag_q.push_back("R10");
    drive(op, 0);
  endtask

  // bench-side restatement of offset sizing from R4..R8
  task automatic send_grp(input logic [7:0] mrm, input logic [15:0] dv,
                          input logic [15:0] iv, input int gmax);
    exp_t e = '0;
    int nd;
    string t;
    logic [1:0] md = mrm[7:6];
    logic [2:0] rm = mrm[2:0];
    if (md == 2'd3)                  begin nd = 0; t = "R8,R3,R9";  end
    else if (md == 2'd1)             begin nd = 1; t = "R5,R3,R9";  end
    else if (md == 2'd2)             begin nd = 2; t = "R6,R3,R9";  end
    else if (rm == 3'd6)             begin nd = 2; t = "R7,R3,R9";  end
    else                             begin nd = 0; t = "R4,R3,R9";  end
    if (gmax != 0) t = {t, ",R11"};
    e.opc = 8'h81;
    e.md  = md;
    e.rg  = mrm[5:3];
    e.rm  = rm;
    if (nd == 1)      e.disp = (dv[7] ? 16'hFF00 : 16'h0000) | {8'h00, dv[7:0]};
    else if (nd == 2) e.disp = dv;
    else              e.disp = 16'h0000;
    e.imm = iv;
    e.len = 3'(4 + nd);
    exp_q.push_back(e);
    tag_q.push_back(t);
    drive(8'h81, gmax);
    drive(mrm, gmax);
    if (nd >= 1) drive(dv[7:0], gmax);
    if (nd == 2) drive(dv[15:8], gmax);
    drive(iv[7:0], gmax);
    drive(iv[15:8], gmax);
  endtask

  // monitor: compare every report against the queue of expected results
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      exp_t g, e;
      string t;
      g = {out_illegal, out_opcode, out_mod, out_reg, out_rm, out_disp, out_imm, out_len};
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected report got=%h expected none", g);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (g !== e) begin
          n_bad++;
          $display("FAIL %s got ill=%b opc=%h mod=%0d reg=%0d rm=%0d disp=%h imm=%h len=%0d exp ill=%b opc=%h mod=%0d reg=%0d rm=%0d disp=%h imm=%h len=%0d",
                   t, g.ill, g.opc, g.md, g.rg, g.rm, g.disp, g.imm, g.len,
                   e.ill, e.opc, e.md, e.rg, e.rm, e.disp, e.imm, e.len);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=timeout expected=completion");
    report();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    repeat (3) @(negedge clk);
    n_chk++;
    if (in_ready !== 1'b0 || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset got ready=%b valid=%b expected 0 0", in_ready, out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 after reset got ready=%b valid=%b expected 1 0", in_ready, out_valid);
    end

    // the two worked examples: R5 and R8
    send_grp(8'h7E, 16'h0008, 16'hABCD, 0);
    send_grp(8'hFA, 16'h0000, 16'hABCD, 0);

    // every push register (R2)
    for (int r = 0; r < 8; r++) send_push(3'(r));

    // every descriptor value, back to back
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b = 8'(i);
      send_grp(b, {b + 8'h33, b ^ 8'h5A}, {b ^ 8'hC3, ~b}, 0);
    end

    // every unsupported opcode, each followed by a push (R10)
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o = 8'(op);
      if (o[7:3] != 5'b01010 && o != 8'h81) begin
        send_bad(o);
        send_push(o[2:0]);
      end
    end

    // stalls inside instructions (R11)
    for (int i = 0; i < 256; i += 3) begin
      logic [7:0] b = 8'(i);
      send_grp(b, {~b, b + 8'h91}, {b, b ^ 8'h0F}, 3);
      send_push(b[2:0]);
    end

    go_idle(6);
    n_chk++;
    if (exp_q.size() != 0 || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 pending got=%0d valid=%b expected 0 0", exp_q.size(), out_valid);
    end
    report();
  end

endmodule